// File: doc/BRIEF.md
# Cluster Hotplug Manager

This block supervises the shared power domain of one processor cluster of four cores. It keeps a use count per core and serves three kinds of per-core request, boot, die and kill, one at a time. Each count shows whether a core is in use. From the counts the block decides whether a request is the first to wake a sleeping cluster, which starts the full cluster power-up, or the last to leave it, which starts the cluster power-down once the cores are idle.

Core-level power switching is left to a per-core sequencer. The block hands that sequencer a one-cycle power-up or power-down request. Waits for idle status are timed by an external microsecond tick, with a poll period, an overall timeout and a settle delay set by parameters. Every request ends with a one-cycle response that carries a result code and the core index. Result codes: 0 = OK, 1 = ABORT (shutdown abandoned), 2 = TIMEOUT, 3 = ERROR.

Top module: `hpm_cluster_ctrl`

## Requirements
- R1: After reset the cluster outputs (cluster reset, bus-inactive, power gate, all-core power-on reset, first-comer) are all 0. Core 0 has a count of 1 and every other core has a count of 0.
- R2: A boot request for a core with a nonzero count gives response code 0. It issues no core power-up request and changes no cluster output, but the count still goes up by one (saturating).
- R3: A boot request that finds every count at zero sets first-comer to 1 and then works through these steps in order: bus-inactive high, all-core power-on reset high, cluster reset high, power gate low. It waits at least SETTLE_US ticks, drops the cluster reset, drops bus-inactive, and finally issues the core power-up request together with a drop of the all-core reset.
- R4: A boot request for a zero-count core while another core is in use clears first-comer and issues exactly one core power-up request for that core. The cluster outputs do not change.
- R5: A die request on a zero count gives code 3 and leaves the count unchanged. Otherwise it decrements the count and gives code 1 if the new count is 1, or code 3 if the new count is above 1.
- R6: A die request that takes a count to 0 while all other counts are 0 sets bus-inactive and gives code 0. If another core is still in use, bus-inactive is left unchanged.
- R7: A kill request checks its core once every POLL_US ticks. When the count is 0 and that core's idle status is high, it issues one core power-down request.
- R8: If the core does not become ready within TIMEOUT_US ticks, the kill gives code 2 and issues no power-down request.
- R9: After a core power-down with all counts at 0, the block polls the L2 idle status. Once that status is seen, it raises the cluster reset, then the power gate, waits SETTLE_US ticks and gives code 0.
- R10: If the L2 idle status does not come within TIMEOUT_US ticks, the kill gives code 0 and the cluster stays powered.
- R11: Requests are latched and served one at a time. Among waiting requests boot comes before die and die before kill, and within a kind the lowest core index goes first.
- R12: The power gate is never high unless the cluster reset is high, and the cluster reset is only released while bus-inactive is high and the gate is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| boot_req | input | N | Per-core boot request pulses |
| die_req | input | N | Per-core die request pulses |
| kill_req | input | N | Per-core kill request pulses |
| core_wfi | input | N | Per-core idle (wait-for-interrupt) status |
| l2_wfi | input | 1 | Cluster L2 idle status |
| clus_rst | output | 1 | Cluster debug/bus/L2 reset, 1 = asserted |
| bus_inact | output | 1 | Cluster bus-inactive indication |
| clus_gate | output | 1 | Cluster power gate, 1 = power removed |
| core_por_all | output | 1 | Hold all core power-on resets |
| first_comer | output | 1 | Last power-up woke the cluster |
| core_up_req | output | N | One-cycle core power-up request |
| core_dn_req | output | N | One-cycle core power-down request |
| resp_valid | output | 1 | Response strobe |
| resp_code | output | 2 | Result code of the served request |
| resp_core | output | $clog2(N) | Core index of the served request |

## Verification
Several properties are checked on every cycle: the power gate stays inside the cluster reset, the reset is only released with bus-inactive high, power-up and power-down requests are one-hot, a power-up request never meets a gated or reset cluster, a count is never decremented at zero, and a timeout never comes with a power-down request. The ordering of the power-up and power-down steps, the settle and timeout spans, the abort and error codes, the first-comer decision and the priority among simultaneous requests can only be shown by the bench scenarios.

// File: rtl/hpm_pkg.sv
package hpm_pkg;

  typedef enum logic [1:0] {
    RSP_OK    = 2'd0,
    RSP_ABORT = 2'd1,
    RSP_TMO   = 2'd2,
    RSP_ERR   = 2'd3
  } rsp_e;

  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_BOOT = 2'd1,
    REQ_DIE  = 2'd2,
    REQ_KILL = 2'd3
  } req_e;

  // Index of the lowest set bit; 0 when none is set.
  function automatic int lowest_set(input logic [31:0] v);
    int r;
    r = 0;
    for (int i = 31; i >= 0; i--) if (v[i]) r = i;
    return r;
  endfunction

endpackage

// File: rtl/hpm_timer.sv
module hpm_timer #(
  parameter int POLL_US    = 100,
  parameter int TIMEOUT_US = 100000,
  parameter int SETTLE_US  = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  output logic poll,
  output logic poll_last,
  output logic settle_done
);
  localparam int TW = $clog2(TIMEOUT_US + 1);
  localparam int PW = $clog2(POLL_US + 1);
  localparam logic [TW-1:0] T_LIM = TW'(TIMEOUT_US);
  localparam logic [TW-1:0] S_LIM = TW'(SETTLE_US);
  localparam logic [PW-1:0] P_END = PW'(POLL_US - 1);

  logic [TW-1:0] el_q;
  logic [PW-1:0] pc_q;

  assign poll        = run && tick && (pc_q == P_END);
  assign poll_last   = poll && (el_q >= T_LIM - 1'b1);
  assign settle_done = run && (el_q >= S_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      el_q <= '0;
      pc_q <= '0;
    end else if (!run) begin
      el_q <= '0;
      pc_q <= '0;
    end else if (tick) begin
      pc_q <= (pc_q == P_END) ? '0 : pc_q + 1'b1;
      el_q <= (el_q == T_LIM) ? el_q : el_q + 1'b1;
    end
  end

  // R8: the elapsed count saturates at the timeout and never wraps
  a_r8_elapsed_capped: assert property (@(posedge clk) disable iff (!rst_n)
    el_q <= T_LIM);

endmodule

// File: rtl/hpm_arb.sv
module hpm_arb import hpm_pkg::*; #(
  parameter int N = 4,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  boot_req,
  input  logic [N-1:0]  die_req,
  input  logic [N-1:0]  kill_req,
  input  logic          take,
  output logic          gnt_valid,
  output req_e          gnt_kind,
  output logic [IW-1:0] gnt_core
);
  logic [N-1:0] pb_q, pd_q, pk_q;
  logic [N-1:0] sel;

  always_comb begin
    gnt_valid = |{pb_q, pd_q, pk_q};
    gnt_kind  = REQ_NONE;
    gnt_core  = '0;
    if (|pb_q) begin
      gnt_kind = REQ_BOOT;
      gnt_core = IW'(lowest_set(32'(pb_q)));
    end else if (|pd_q) begin
      gnt_kind = REQ_DIE;
      gnt_core = IW'(lowest_set(32'(pd_q)));
    end else if (|pk_q) begin
      gnt_kind = REQ_KILL;
      gnt_core = IW'(lowest_set(32'(pk_q)));
    end
    sel = (take && gnt_valid) ? (N'(1) << gnt_core) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pb_q <= '0;
      pd_q <= '0;
      pk_q <= '0;
    end else begin
      pb_q <= (pb_q & ~((gnt_kind == REQ_BOOT) ? sel : '0)) | boot_req;
      pd_q <= (pd_q & ~((gnt_kind == REQ_DIE)  ? sel : '0)) | die_req;
      pk_q <= (pk_q & ~((gnt_kind == REQ_KILL) ? sel : '0)) | kill_req;
    end
  end

  // R11: a die or kill is never granted while a boot is waiting
  a_r11_boot_first: assert property (@(posedge clk) disable iff (!rst_n)
    (take && gnt_valid && gnt_kind != REQ_BOOT) |-> (pb_q == '0));

endmodule

// File: rtl/hpm_counts.sv
module hpm_counts #(
  parameter int N  = 4,
  parameter int CW = 2,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  input  logic [IW-1:0] idx,
  output logic [CW-1:0] cur,
  output logic          others_zero
);
  localparam logic [CW-1:0] CMAX = '1;

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] v);
    return (v == CMAX) ? v : v + 1'b1;
  endfunction

  function automatic logic [CW-1:0] drop(input logic [CW-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  logic [N*CW-1:0] flat;

  for (genvar g = 0; g < N; g++) begin : g_core
    logic [CW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                q <= CW'(g == 0 ? 1 : 0);
      else if (idx == IW'(g)) begin
        if (inc)      q <= bump(q);
        else if (dec) q <= drop(q);
      end
    end
    assign flat[g*CW +: CW] = q;
  end

  assign cur = flat[idx*CW +: CW];

  always_comb begin
    others_zero = 1'b1;
    for (int i = 0; i < N; i++)
      if (IW'(i) != idx && flat[i*CW +: CW] != '0) others_zero = 1'b0;
  end

  // R5: the controller never decrements a count that is already zero
  a_r5_no_dec_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (cur != '0));

  // R2: increment and decrement never coincide
  a_r2_single_op: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc && dec));

endmodule

// File: rtl/hpm_cluster_ctrl.sv
module hpm_cluster_ctrl import hpm_pkg::*; #(
  parameter int N          = 4,
  parameter int CW         = 2,
  parameter int POLL_US    = 100,
  parameter int TIMEOUT_US = 100000,
  parameter int SETTLE_US  = 20,
  parameter int IW         = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          us_tick,
  input  logic [N-1:0]  boot_req,
  input  logic [N-1:0]  die_req,
  input  logic [N-1:0]  kill_req,
  input  logic [N-1:0]  core_wfi,
  input  logic          l2_wfi,
  output logic          clus_rst,
  output logic          bus_inact,
  output logic          clus_gate,
  output logic          core_por_all,
  output logic          first_comer,
  output logic [N-1:0]  core_up_req,
  output logic [N-1:0]  core_dn_req,
  output logic          resp_valid,
  output logic [1:0]    resp_code,
  output logic [IW-1:0] resp_core
);
  typedef enum logic [3:0] {
    S_IDLE, S_PU_BUS, S_PU_POR, S_PU_RST, S_PU_GATE, S_PU_WAIT, S_PU_RELR,
    S_PU_RELB, S_CORE_UP, S_KPOLL, S_KDN, S_L2POLL, S_CD_RST, S_CD_GATE, S_CD_WAIT
  } st_e;

  st_e           st;
  logic [IW-1:0] c_q, idx;
  logic          gnt_valid, take;
  req_e          gnt_kind;
  logic [IW-1:0] gnt_core;
  logic [CW-1:0] cur;
  logic          others_zero, cnt_inc, cnt_dec;
  logic          tmr_run, poll, poll_last, settle_done;

  // named events, also used by the assertions
  logic boot_served, boot_busy, die_served, kill_ready;

  assign take        = (st == S_IDLE);
  assign idx         = take ? gnt_core : c_q;
  assign boot_served = take && gnt_valid && (gnt_kind == REQ_BOOT);
  assign die_served  = take && gnt_valid && (gnt_kind == REQ_DIE);
  assign boot_busy   = boot_served && (cur != '0);
  assign cnt_inc     = boot_busy || (st == S_CORE_UP);
  assign cnt_dec     = die_served && (cur != '0);
  assign kill_ready  = (st == S_KPOLL) && poll && (cur == '0) && core_wfi[c_q];
  assign tmr_run     = (st == S_PU_WAIT) || (st == S_KPOLL) ||
                       (st == S_L2POLL) || (st == S_CD_WAIT);

  hpm_arb #(.N(N), .IW(IW)) u_arb (
    .clk, .rst_n, .boot_req, .die_req, .kill_req, .take,
    .gnt_valid, .gnt_kind, .gnt_core
  );

  hpm_counts #(.N(N), .CW(CW), .IW(IW)) u_cnt (
    .clk, .rst_n, .inc(cnt_inc), .dec(cnt_dec), .idx, .cur, .others_zero
  );

  hpm_timer #(.POLL_US(POLL_US), .TIMEOUT_US(TIMEOUT_US), .SETTLE_US(SETTLE_US)) u_tmr (
    .clk, .rst_n, .tick(us_tick), .run(tmr_run), .poll, .poll_last, .settle_done
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;        c_q <= '0;
      clus_rst <= 1'b0;    bus_inact <= 1'b0;   clus_gate <= 1'b0;
      core_por_all <= 1'b0; first_comer <= 1'b0;
      core_up_req <= '0;   core_dn_req <= '0;
      resp_valid <= 1'b0;  resp_code <= RSP_OK; resp_core <= '0;
    end else begin
      core_up_req <= '0;
      core_dn_req <= '0;
      resp_valid  <= 1'b0;
      unique case (st)
        S_IDLE: if (gnt_valid) begin
          c_q <= gnt_core;
          unique case (gnt_kind)
            REQ_BOOT: begin
              if (cur != '0) begin
                resp_valid <= 1'b1; resp_code <= RSP_OK; resp_core <= gnt_core;
              end else if (others_zero) begin
                first_comer <= 1'b1; st <= S_PU_BUS;
              end else begin
                first_comer <= 1'b0; st <= S_CORE_UP;
              end
            end
            REQ_DIE: begin
              resp_valid <= 1'b1; resp_core <= gnt_core;
              if (cur == '0)              resp_code <= RSP_ERR;
              else if (cur == CW'(2))     resp_code <= RSP_ABORT;
              else if (cur > CW'(2))      resp_code <= RSP_ERR;
              else begin
                resp_code <= RSP_OK;
                if (others_zero) bus_inact <= 1'b1;
              end
            end
            REQ_KILL: st <= S_KPOLL;
            default:  st <= S_IDLE;
          endcase
        end
        S_PU_BUS:  begin bus_inact <= 1'b1;    st <= S_PU_POR;  end
        S_PU_POR:  begin core_por_all <= 1'b1; st <= S_PU_RST;  end
        S_PU_RST:  begin clus_rst <= 1'b1;     st <= S_PU_GATE; end
        S_PU_GATE: begin clus_gate <= 1'b0;    st <= S_PU_WAIT; end
        S_PU_WAIT: if (settle_done) st <= S_PU_RELR;
        S_PU_RELR: begin clus_rst <= 1'b0;     st <= S_PU_RELB; end
        S_PU_RELB: begin bus_inact <= 1'b0;    st <= S_CORE_UP; end
        S_CORE_UP: begin
          core_up_req[c_q] <= 1'b1; core_por_all <= 1'b0;
          resp_valid <= 1'b1; resp_code <= RSP_OK; resp_core <= c_q;
          st <= S_IDLE;
        end
        S_KPOLL: if (kill_ready) st <= S_KDN;
                 else if (poll_last) begin
                   resp_valid <= 1'b1; resp_code <= RSP_TMO; resp_core <= c_q;
                   st <= S_IDLE;
                 end
        S_KDN: begin
          core_dn_req[c_q] <= 1'b1;
          if (others_zero) st <= S_L2POLL;
          else begin
            resp_valid <= 1'b1; resp_code <= RSP_OK; resp_core <= c_q; st <= S_IDLE;
          end
        end
        S_L2POLL: if (poll && l2_wfi) st <= S_CD_RST;
                  else if (poll_last) begin
                    resp_valid <= 1'b1; resp_code <= RSP_OK; resp_core <= c_q;
                    st <= S_IDLE;
                  end
        S_CD_RST:  begin clus_rst <= 1'b1;  st <= S_CD_GATE; end
        S_CD_GATE: begin clus_gate <= 1'b1; st <= S_CD_WAIT; end
        S_CD_WAIT: if (settle_done) begin
          resp_valid <= 1'b1; resp_code <= RSP_OK; resp_core <= c_q; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R12: power is only gated while the cluster is held in reset
  a_r12_gate_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    clus_gate |-> clus_rst);

  // R12: reset release happens with the bus quiet and power applied
  a_r12_release_safe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clus_rst) |-> (bus_inact && !clus_gate));

  // R4: at most one core power-up request, and only into a live cluster
  a_r4_up_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(core_up_req));
  a_r4_up_live: assert property (@(posedge clk) disable iff (!rst_n)
    (|core_up_req) |-> (!clus_gate && !clus_rst && !bus_inact));

  // R7: at most one core power-down request at a time
  a_r7_dn_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(core_dn_req));

  // R8: a timed-out kill is never paired with a power-down request
  a_r8_tmo_no_dn: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_code == RSP_TMO) |-> (core_dn_req == '0 && $past(core_dn_req) == '0));

endmodule

// File: tb/hpm_cluster_ctrl_test.sv
`timescale 1ns/1ps
module hpm_cluster_ctrl_test;
  localparam int N = 4, CW = 2, POLL = 4, TMO = 40, SETTLE = 5, IW = 2;

  logic clk = 1'b0, rst_n = 1'b0, us_tick = 1'b0, l2_wfi = 1'b0;
  logic [N-1:0] boot_req = '0, die_req = '0, kill_req = '0, core_wfi = '0;
  logic clus_rst, bus_inact, clus_gate, core_por_all, first_comer, resp_valid;
  logic [N-1:0] core_up_req, core_dn_req;
  logic [1:0] resp_code;
  logic [IW-1:0] resp_core;

  int checks = 0, fails = 0, cyc = 0;
  int up_seen [N];
  int dn_seen [N];
  int t_por_r, t_rst_r, t_rst_f, t_gate_r, t_gate_f, t_bus_f, t_up;
  logic p_por = 1'b0, p_rst = 1'b0, p_gate = 1'b0, p_bus = 1'b0;

  always #10 clk = ~clk;

  hpm_cluster_ctrl #(.N(N), .CW(CW), .POLL_US(POLL), .TIMEOUT_US(TMO), .SETTLE_US(SETTLE)) uut (
    .clk, .rst_n, .us_tick, .boot_req, .die_req, .kill_req, .core_wfi, .l2_wfi,
    .clus_rst, .bus_inact, .clus_gate, .core_por_all, .first_comer,
    .core_up_req, .core_dn_req, .resp_valid, .resp_code, .resp_core
  );

  // microsecond tick every other cycle, plus an event monitor
  always @(negedge clk) begin
    us_tick = ~us_tick;
    cyc = cyc + 1;
    for (int i = 0; i < N; i++) begin
      if (core_up_req[i]) begin up_seen[i]++; t_up = cyc; end
      if (core_dn_req[i]) dn_seen[i]++;
    end
    if (core_por_all && !p_por) t_por_r = cyc;
    if (clus_rst && !p_rst) t_rst_r = cyc;
    if (!clus_rst && p_rst) t_rst_f = cyc;
    if (clus_gate && !p_gate) t_gate_r = cyc;
    if (!clus_gate && p_gate) t_gate_f = cyc;
    if (!bus_inact && p_bus) t_bus_f = cyc;
    p_por = core_por_all; p_rst = clus_rst; p_gate = clus_gate; p_bus = bus_inact;
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  task automatic expect_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_ok(input string tag, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic fire(input logic [N-1:0] b, input logic [N-1:0] d, input logic [N-1:0] k);
    @(negedge clk);
    boot_req = b; die_req = d; kill_req = k;
    @(negedge clk);
    boot_req = '0; die_req = '0; kill_req = '0;
  endtask

  task automatic get_resp(output int code, output int core, output int lat);
    int start;
    start = cyc; code = -1; core = -1; lat = -1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (resp_valid) begin
        code = resp_code; core = resp_core; lat = cyc - start;
        break;
      end
    end
    #1;
  endtask

  task automatic clear_times();
    t_por_r = -1; t_rst_r = -1; t_rst_f = -1; t_gate_r = -1;
    t_gate_f = -1; t_bus_f = -1; t_up = -1;
  endtask

  task automatic sc_reset();
    int c, k, l;
    expect_eq("R1 clus_rst", clus_rst, 0);
    expect_eq("R1 bus_inact", bus_inact, 0);
    expect_eq("R1 clus_gate", clus_gate, 0);
    expect_eq("R1 core_por_all", core_por_all, 0);
    expect_eq("R1 first_comer", first_comer, 0);
    fire(4'b0000, 4'b0100, 4'b0000);   // core 2 starts at zero
    get_resp(c, k, l);
    expect_eq("R1 core2 zero count (R5 die on zero)", c, 3);
  endtask

  task automatic sc_busy_boot();
    int c, k, l, u;
    u = up_seen[0];
    fire(4'b0001, 4'b0000, 4'b0000);
    get_resp(c, k, l);
    expect_eq("R2 busy boot code", c, 0);
    expect_eq("R2 no power-up", up_seen[0] - u, 0);
    expect_eq("R2 cluster untouched", {clus_rst, bus_inact, clus_gate, core_por_all}, 0);
    fire(4'b0000, 4'b0001, 4'b0000);   // 2 -> 1
    get_resp(c, k, l);
    expect_eq("R5 die to one aborts (R2 count rose)", c, 1);
  endtask

  task automatic sc_warm_boot();
    int c, k, l, u;
    u = up_seen[1];
    fire(4'b0010, 4'b0000, 4'b0000);
    get_resp(c, k, l);
    expect_eq("R4 warm boot code", c, 0);
    expect_eq("R4 one power-up core1", up_seen[1] - u, 1);
    expect_eq("R4 first_comer low", first_comer, 0);
    expect_eq("R4 cluster untouched", {clus_rst, bus_inact, clus_gate}, 0);
  endtask

  task automatic sc_die_paths();
    int c, k, l;
    fire(4'b0000, 4'b0010, 4'b0000);
    get_resp(c, k, l);
    expect_eq("R6 non-last die code", c, 0);
    expect_eq("R6 non-last keeps bus active", bus_inact, 0);
    for (int i = 0; i < 3; i++) begin
      fire(4'b1000, 4'b0000, 4'b0000);
      get_resp(c, k, l);
    end
    fire(4'b0000, 4'b1000, 4'b0000);   // 3 -> 2
    get_resp(c, k, l);
    expect_eq("R5 die leaving two is error", c, 3);
    fire(4'b0000, 4'b1000, 4'b0000);   // 2 -> 1
    get_resp(c, k, l);
    expect_eq("R5 die leaving one aborts", c, 1);
    fire(4'b0000, 4'b1000, 4'b0000);   // 1 -> 0
    get_resp(c, k, l);
    expect_eq("R5 die to zero code", c, 0);
  endtask

  task automatic sc_kill_ok();
    int c, k, l, d;
    core_wfi = 4'b0010;
    d = dn_seen[1];
    fire(4'b0000, 4'b0000, 4'b0010);
    get_resp(c, k, l);
    expect_eq("R7 kill code", c, 0);
    expect_eq("R7 one power-down core1", dn_seen[1] - d, 1);
    expect_ok("R7 waited one poll period", l >= 2 * POLL - 2, l, 2 * POLL);
    expect_eq("R7 cluster stays up", {clus_rst, clus_gate}, 0);
  endtask

  task automatic sc_kill_tmo();
    int c, k, l, d;
    core_wfi = 4'b0001;                // idle but still counted
    d = dn_seen[0];
    fire(4'b0000, 4'b0000, 4'b0001);
    get_resp(c, k, l);
    expect_eq("R8 timeout code", c, 2);
    expect_eq("R8 no power-down", dn_seen[0] - d, 0);
    expect_ok("R8 full timeout span", l >= 2 * TMO - 4 && l <= 2 * TMO + 12, l, 2 * TMO);
  endtask

  task automatic sc_last_die();
    int c, k, l;
    fire(4'b0000, 4'b0001, 4'b0000);
    get_resp(c, k, l);
    expect_eq("R6 last die code", c, 0);
    expect_eq("R6 last die sets bus_inact", bus_inact, 1);
    expect_eq("R6 gate still open", clus_gate, 0);
  endtask

  task automatic sc_l2_tmo();
    int c, k, l, d;
    core_wfi = 4'b0001; l2_wfi = 1'b0;
    d = dn_seen[0];
    fire(4'b0000, 4'b0000, 4'b0001);
    get_resp(c, k, l);
    expect_eq("R10 L2 timeout still ok", c, 0);
    expect_eq("R10 core powered down", dn_seen[0] - d, 1);
    expect_eq("R10 cluster left powered", {clus_rst, clus_gate}, 0);
    expect_ok("R10 waited L2 timeout", l >= 2 * TMO, l, 2 * TMO);
  endtask

  task automatic sc_l2_ok();
    int c, k, l, d;
    l2_wfi = 1'b1;
    clear_times();
    d = dn_seen[0];
    fire(4'b0000, 4'b0000, 4'b0001);
    get_resp(c, k, l);
    expect_eq("R9 cluster down code", c, 0);
    expect_eq("R9 core powered down", dn_seen[0] - d, 1);
    expect_eq("R9 reset and gate set", {clus_rst, clus_gate}, 2'b11);
    expect_ok("R9 reset before gate", t_rst_r > 0 && t_rst_r < t_gate_r, t_rst_r, t_gate_r);
    expect_ok("R9 settle after gate", cyc - t_gate_r >= 2 * SETTLE - 2, cyc - t_gate_r, 2 * SETTLE);
  endtask

  task automatic sc_cold_boot();
    int c, k, l, u;
    core_wfi = '0; l2_wfi = 1'b0;
    clear_times();
    u = up_seen[2];
    fire(4'b0100, 4'b0000, 4'b0000);
    get_resp(c, k, l);
    expect_eq("R3 cold boot code", c, 0);
    expect_eq("R3 first_comer set", first_comer, 1);
    expect_eq("R3 one power-up core2", up_seen[2] - u, 1);
    expect_ok("R3 por before gate open", t_por_r > 0 && t_por_r < t_gate_f, t_por_r, t_gate_f);
    expect_ok("R3 settle before reset release", t_rst_f - t_gate_f >= 2 * SETTLE, t_rst_f - t_gate_f, 2 * SETTLE);
    expect_ok("R3 reset release before bus", t_rst_f < t_bus_f, t_rst_f, t_bus_f);
    expect_ok("R3 bus before core up", t_bus_f < t_up, t_bus_f, t_up);
    expect_eq("R3 cluster live", {clus_rst, bus_inact, clus_gate, core_por_all}, 0);
  endtask

  task automatic sc_priority();
    int c1, k1, c2, k2, c3, k3, l, d, u;
    core_wfi = 4'b0100;
    d = dn_seen[2]; u = up_seen[3];
    fire(4'b1000, 4'b0100, 4'b0100);
    get_resp(c1, k1, l);
    expect_eq("R11 boot served first", k1, 3);
    expect_eq("R11 boot powered core3", up_seen[3] - u, 1);
    get_resp(c2, k2, l);
    expect_eq("R11 die served second", k2, 2);
    expect_eq("R11 no power-down before kill", dn_seen[2] - d, 0);
    get_resp(c3, k3, l);
    expect_eq("R11 kill served last", k3, 2);
    expect_eq("R11 kill powered down core2", dn_seen[2] - d, 1);
    expect_eq("R11 codes ok", c1 + c2 + c3, 0);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin up_seen[i] = 0; dn_seen[i] = 0; end
    clear_times();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    sc_reset();
    sc_busy_boot();
    sc_warm_boot();
    sc_die_paths();
    sc_kill_ok();
    sc_kill_tmo();
    sc_last_die();
    sc_l2_tmo();
    sc_l2_ok();
    sc_cold_boot();
    sc_priority();
    summary();
    $finish;
  end

endmodule